// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a free-running timer. A prescale counter divides the peripheral clock, and the timer count advances by one each time the prescale counter completes its programmed span. There are four compare channels, and each one watches the timer count. On a match, each channel can raise its own interrupt flag, restart the count from zero, or freeze the timer, in any combination. Each channel also owns one output level, which a match can leave alone, force low, force high or invert.

Software programs the block over a small synchronous register bus with an address, a write strobe and write data. Read data comes back one clock after the address is presented. Interrupt flags stay set until software writes a one to them. The block's interrupt line is high while any flag is set.

Top module: `tmr_match_timer`

## Requirements
- R1: The prescale counter rises by one on each enabled clock. On a clock where it equals the prescale value (address 1), it goes back to 0 and the timer count rises by one. A prescale value of 0 advances the timer on every enabled clock, and the timer count wraps from all ones to 0.
- R2: The control register is at address 0, with bit 0 the run enable and bit 1 the counter clear. While bit 1 is 1, the timer count (address 3) and the prescale count (address 2) read 0. While bit 0 is 0, both counts hold their value.
- R3: Bit 3k+1 of the match control register (address 5) is the restart action of channel k. A match on channel k with this bit set makes the timer count and the prescale count 0 on the next clock, so the count runs 0 to M and repeats with a period of M+1.
- R4: Bit 3k+2 of the match control register is the freeze action of channel k. A match with this bit set holds both counts at their matched values and clears run enable to 0. Counting resumes only after software sets run enable again.
- R5: Bit 3k of the match control register is the flag action of channel k. A match with this bit set sets bit k of the flag register (address 4). A match without it leaves the flag unchanged. The irq output is 1 while any flag bit is 1.
- R6: Writing the flag register clears each bit written as 1 and keeps each bit written as 0. A match that sets a flag wins over a clear of that flag in the same clock.
- R7: The output register (address 6) holds the level of channel k in bit k. It holds the action code of channel k in bits NUM_CH+2k+1:NUM_CH+2k, where 00 means keep, 01 means drive low, 10 means drive high and 11 means invert. matchOut[k] shows the level. A software write sets the levels directly, and a match action on a channel wins over a software write to that channel in the same clock.
- R8: A channel matches only in the clock after the timer count has taken its compare value, either by counting or by a match restart. A count that sits at that value, because of a prescale wait, a disable or a freeze, does not match again.
- R9: Reads are registered: rdData shows the register at the address sampled on the previous clock. Match value k is at address 8+k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Registered read data |
| matchOut | output | NUM_CH | Per-channel output levels |
| irq | output | 1 | High while any interrupt flag is set |

## Verification
The bench builds the block with a counter width of 8 bits, four channels and a 32-bit bus. The narrow counter lets a run that resumes after a freeze travel the whole count range, wrap, and come back to the same compare value within a few hundred clocks. The freeze, the flag and the output inversion are then seen a second time. A prescale value of 3 keeps the count on one compare value for four clocks, and this shows that the inversion and the flag act only once per arrival.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Strobes from the register/control side to the counting datapath.
  typedef struct packed {
    logic clearAll;   // software clear: hold both counters at zero
    logic matchRst;   // a match with restart action fired this cycle
    logic countEn;    // counting allowed this cycle
  } tmrStrobe_t;

  localparam int A_CTRL = 0;
  localparam int A_PRE  = 1;
  localparam int A_PC   = 2;
  localparam int A_TC   = 3;
  localparam int A_FLAG = 4;
  localparam int A_MCR  = 5;
  localparam int A_EMR  = 6;
  localparam int A_MR   = 8;

endpackage

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic [CNT_W-1:0] prescale,
  output logic [CNT_W-1:0] tc,
  output logic [CNT_W-1:0] pc,
  output logic             tcFresh
);

  logic wrapTick;
  assign wrapTick = (pc == prescale);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tc      <= '0;
      pc      <= '0;
      tcFresh <= 1'b0;
    end else if (strb.clearAll) begin
      tc      <= '0;
      pc      <= '0;
      tcFresh <= 1'b0;
    end else if (strb.matchRst) begin
      tc      <= '0;
      pc      <= '0;
      tcFresh <= 1'b1;
    end else if (strb.countEn) begin
      if (wrapTick) begin
        pc      <= '0;
        tc      <= tc + CNT_W'(1);
        tcFresh <= 1'b1;
      end else begin
        pc      <= pc + CNT_W'(1);
        tcFresh <= 1'b0;
      end
    end else begin
      tcFresh <= 1'b0;
    end
  end

  AST_CLEAR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (tc == '0 && pc == '0)); // R2

  AST_TC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(tc) |-> (tc == $past(tc) + CNT_W'(1) || tc == '0)); // R1

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countEn && !strb.clearAll && !strb.matchRst) |=> ($stable(tc) && $stable(pc))); // R4

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  tc,
  input  logic [CNT_W-1:0]  pc,
  input  logic              tcFresh,
  output tmrStrobe_t        strb,
  output logic [CNT_W-1:0]  prescale,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] matchOut,
  output logic              irq
);

  localparam int MCR_W = 3 * NUM_CH;
  localparam int EMC_W = 2 * NUM_CH;

  logic              enBit, rstBit;
  logic [CNT_W-1:0]  mr [NUM_CH];
  logic [MCR_W-1:0]  mcr;
  logic [EMC_W-1:0]  emrCtl;
  logic [NUM_CH-1:0] extLvl, extNext;
  logic [NUM_CH-1:0] flags;
  logic [NUM_CH-1:0] hit, irqEnV, rstEnV, stopEnV;
  logic              anyStop, anyRst;
  logic              wrCtrl, wrPre, wrFlag, wrMcr, wrEmr;
  logic [DATA_W-1:0] rdNext;

  assign wrCtrl = wrEn && (addr == ADDR_W'(A_CTRL));
  assign wrPre  = wrEn && (addr == ADDR_W'(A_PRE));
  assign wrFlag = wrEn && (addr == ADDR_W'(A_FLAG));
  assign wrMcr  = wrEn && (addr == ADDR_W'(A_MCR));
  assign wrEmr  = wrEn && (addr == ADDR_W'(A_EMR));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign hit[k]     = tcFresh && (tc == mr[k]);
    assign irqEnV[k]  = mcr[3*k];
    assign rstEnV[k]  = mcr[3*k+1];
    assign stopEnV[k] = mcr[3*k+2];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        mr[k] <= '0;
      else if (wrEn && addr == ADDR_W'(A_MR + k))
        mr[k] <= wrData[CNT_W-1:0];
    end

    always_comb begin
      extNext[k] = wrEmr ? wrData[k] : extLvl[k];
      if (hit[k]) begin
        case (emrCtl[2*k+1:2*k])
          2'b01:   extNext[k] = 1'b0;
          2'b10:   extNext[k] = 1'b1;
          2'b11:   extNext[k] = ~extLvl[k];
          default: ;
        endcase
      end
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
      (hit[k] && irqEnV[k]) |=> flags[k]); // R5
  end

  assign anyStop = |(hit & stopEnV);
  assign anyRst  = |(hit & rstEnV);

  assign strb.clearAll = rstBit;
  assign strb.matchRst = anyRst;
  assign strb.countEn  = enBit && !anyStop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit    <= 1'b0;
      rstBit   <= 1'b0;
      prescale <= '0;
      mcr      <= '0;
      emrCtl   <= '0;
      extLvl   <= '0;
      flags    <= '0;
    end else begin
      if (wrCtrl) begin
        enBit  <= wrData[0];
        rstBit <= wrData[1];
      end
      if (anyStop) enBit <= 1'b0;
      if (wrPre) prescale <= wrData[CNT_W-1:0];
      if (wrMcr) mcr <= wrData[MCR_W-1:0];
      if (wrEmr) emrCtl <= wrData[NUM_CH+EMC_W-1:NUM_CH];
      extLvl <= extNext;
      flags  <= (flags & ~(wrFlag ? wrData[NUM_CH-1:0] : '0)) | (hit & irqEnV);
    end
  end

  always_comb begin
    rdNext = '0;
    case (addr)
      ADDR_W'(A_CTRL): rdNext[1:0] = {rstBit, enBit};
      ADDR_W'(A_PRE):  rdNext = DATA_W'(prescale);
      ADDR_W'(A_PC):   rdNext = DATA_W'(pc);
      ADDR_W'(A_TC):   rdNext = DATA_W'(tc);
      ADDR_W'(A_FLAG): rdNext[NUM_CH-1:0] = flags;
      ADDR_W'(A_MCR):  rdNext[MCR_W-1:0] = mcr;
      ADDR_W'(A_EMR):  rdNext[NUM_CH+EMC_W-1:0] = {emrCtl, extLvl};
      default: begin
        for (int k = 0; k < NUM_CH; k++)
          if (addr == ADDR_W'(A_MR + k)) rdNext = DATA_W'(mr[k]);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  assign matchOut = extLvl;
  assign irq      = |flags;

  AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rstN)
    anyStop |=> !enBit); // R4

  AST_MATCH_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (anyRst && !rstBit) |=> (tc == '0 && pc == '0)); // R3

  AST_EXT_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (!(|hit) && !wrEmr) |=> $stable(matchOut)); // R7

endmodule

// File: rtl/tmr_match_timer.sv
module tmr_match_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] matchOut,
  output logic              irq
);

  tmrStrobe_t       strb;
  logic [CNT_W-1:0] tc, pc, prescale;
  logic             tcFresh;

  tmr_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)
  ) i_regs (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .tc(tc), .pc(pc), .tcFresh(tcFresh), .strb(strb), .prescale(prescale),
    .rdData(rdData), .matchOut(matchOut), .irq(irq)
  );

  tmr_count #(.CNT_W(CNT_W)) i_count (
    .clk(clk), .rstN(rstN), .strb(strb), .prescale(prescale),
    .tc(tc), .pc(pc), .tcFresh(tcFresh)
  );

endmodule

// File: tb/test_tmr_match_timer.sv
module test_tmr_match_timer;

  localparam int CNT_W  = 8;
  localparam int DATA_W = 32;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 4;

  localparam int K_RD  = 0;
  localparam int K_OUT = 1;
  localparam int K_IRQ = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wrEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic [NUM_CH-1:0] matchOut;
  logic              irq;

  int checks = 0;
  int errors = 0;
  logic reqFlag = 1'b0;
  logic done = 1'b0;

  int          kindQ[$];
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #10ns clk = ~clk;

  tmr_match_timer #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)
  ) i_tmr_match_timer (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .matchOut(matchOut), .irq(irq)
  );

  // Monitor: pops the scoreboard when a request was presented.
  always @(posedge clk) begin
    if (reqFlag) begin
      int k; logic [31:0] e, a; string t;
      #2ns;
      k = kindQ.pop_front(); e = expQ.pop_front(); t = tagQ.pop_front();
      if (k == K_RD)       a = rdData;
      else if (k == K_OUT) a = 32'(matchOut);
      else                 a = 32'(irq);
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", t, a, e);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); addr = ADDR_W'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic expectVal(input int kind, input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = ADDR_W'(a);
    kindQ.push_back(kind); expQ.push_back(e); tagQ.push_back(tag);
    reqFlag = 1'b1;
    @(negedge clk); reqFlag = 1'b0;
  endtask

  // Enables for 12 idle negedges plus the two write edges: 14 counted clocks.
  task automatic run14();
    wr(0, 32'h1);
    repeat (12) @(negedge clk);
    wr(0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state (R2, R9, R5, R7)
    expectVal(K_RD, 0, 32'h0, "R2 reset ctrl");
    expectVal(K_RD, 3, 32'h0, "R9 reset tc");
    expectVal(K_RD, 4, 32'h0, "R5 reset flags");
    expectVal(K_OUT, 0, 32'h0, "R7 reset matchOut");
    expectVal(K_IRQ, 0, 32'h0, "R5 reset irq");

    // R2: clear bit holds counters at zero even with enable set
    wr(0, 32'h3);
    repeat (10) @(negedge clk);
    expectVal(K_RD, 3, 32'h0, "R2 clear holds tc");
    expectVal(K_RD, 2, 32'h0, "R2 clear holds pc");
    wr(0, 32'h0);

    // R1/R8: prescale 3, ch3 compare 2 with flag and invert action
    wr(1, 32'd3);
    wr(11, 32'd2);
    wr(5, 32'h200);
    wr(6, 32'hC00);
    run14();
    expectVal(K_RD, 3, 32'd3, "R1 tc after 14 clocks prescale 3");
    expectVal(K_RD, 2, 32'd2, "R1 pc after 14 clocks prescale 3");
    expectVal(K_RD, 6, 32'hC08, "R8 single invert while count sits");
    expectVal(K_RD, 4, 32'h8, "R8 single flag set");
    repeat (8) @(negedge clk);
    expectVal(K_RD, 3, 32'd3, "R2 disabled count holds");
    expectVal(K_RD, 11, 32'd2, "R9 match value readback");
    wr(4, 32'h8);
    wr(0, 32'h2); wr(0, 32'h0);

    // R3: restart on ch0 compare 5, prescale 0
    wr(1, 32'd0);
    wr(8, 32'd5);
    wr(5, 32'h2);
    run14();
    expectVal(K_RD, 3, 32'd2, "R3 period 6 after 14 clocks");
    expectVal(K_RD, 4, 32'h0, "R5 no flag without flag action");
    wr(0, 32'h2); wr(0, 32'h0);

    // R4/R5/R7: ch1 compare 4, freeze + flag, invert; prescale 1
    wr(1, 32'd1);
    wr(9, 32'd4);
    wr(5, 32'h28);
    wr(6, 32'hC0);
    wr(0, 32'h1);
    repeat (30) @(negedge clk);
    expectVal(K_RD, 3, 32'd4, "R4 tc frozen at match");
    expectVal(K_RD, 2, 32'd0, "R4 pc frozen");
    expectVal(K_RD, 0, 32'h0, "R4 enable cleared");
    expectVal(K_RD, 4, 32'h2, "R5 flag ch1 set");
    expectVal(K_IRQ, 0, 32'h1, "R5 irq high");
    expectVal(K_OUT, 0, 32'h2, "R7 invert drives matchOut");
    repeat (20) @(negedge clk);
    expectVal(K_RD, 6, 32'hC2, "R8 frozen count no re-match");
    wr(4, 32'h1);
    expectVal(K_RD, 4, 32'h2, "R6 zero bits keep flag");
    wr(4, 32'h2);
    expectVal(K_RD, 4, 32'h0, "R6 one clears flag");
    expectVal(K_IRQ, 0, 32'h0, "R6 irq low after clear");
    // R4 resume: full wrap back to 4 (R1 wrap)
    wr(0, 32'h1);
    repeat (700) @(negedge clk);
    expectVal(K_RD, 3, 32'd4, "R1 wrap returns to compare");
    expectVal(K_RD, 0, 32'h0, "R4 second freeze clears enable");
    expectVal(K_RD, 6, 32'hC0, "R7 second invert");
    expectVal(K_RD, 4, 32'h2, "R5 flag set again");
    wr(4, 32'hF);
    wr(0, 32'h2); wr(0, 32'h0);

    // R7: drive high / drive low, software level write
    wr(5, 32'h100);
    wr(10, 32'd3);
    wr(11, 32'd3);
    wr(1, 32'd0);
    wr(6, 32'h608);
    expectVal(K_RD, 6, 32'h608, "R7 software level write");
    expectVal(K_OUT, 0, 32'h8, "R7 matchOut follows write");
    wr(0, 32'h1);
    repeat (20) @(negedge clk);
    expectVal(K_RD, 3, 32'd3, "R4 freeze ch2");
    expectVal(K_RD, 6, 32'h604, "R7 high and low actions");
    expectVal(K_OUT, 0, 32'h4, "R7 matchOut after actions");
    expectVal(K_RD, 4, 32'h0, "R5 no flags");
    expectVal(K_RD, 10, 32'd3, "R9 match value 2 readback");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule